// File: doc/BRIEF.md
# Edge Period and Pulse-Width Capture

This block times one digital input against a two-level time base. A prescaler divides the module clock into high-resolution ticks. A fixed number of ticks makes one loop period. The input is brought into the clock domain by a two-flop synchronizer. Its edges are detected only on high-resolution ticks, so every measurement is a whole number of ticks. The result is a loop count in the upper bits and a sub-loop tick count in the lower bits.

A two-bit mode selects what is measured:

| Code | Measurement | Starts on | Ends on |
|------|-------------|-----------|---------|
| 0 | Period | Rising edge | Next rising edge |
| 1 | Period | Falling edge | Next falling edge |
| 2 | High phase | Rising edge | Following falling edge |
| 3 | Low phase | Falling edge | Following rising edge |

Each finished measurement updates a result register and raises a one-cycle valid strobe. Two cases are flagged instead of being reported as a value:
- a phase too short to be measured reliably;
- an interval longer than the counter range.

Software uses the block through a small port. A load strobe writes the mode and re-arms capture. A read acknowledge releases the current result. A result that is overwritten before it is acknowledged sets a sticky overrun bit.

Top module: `hpc_capture`

## Requirements
- R1: With mode code 0, the result is the number of high-resolution ticks from one rising edge to the next rising edge.
- R2: With mode code 1, the result is the number of ticks from one falling edge to the next falling edge.
- R3: With mode code 2, the result is the number of ticks from a rising edge to the following falling edge.
- R4: With mode code 3, the result is the number of ticks from a falling edge to the following rising edge.
- R5: `res_data` holds the loop count in bits [W-1:SUB_W] and the tick count within the loop in bits [SUB_W-1:0], where SUB_W = log2(LR_DIV). Example: with LR_DIV = 4, 13 ticks reads as loop 3, sub 1.
- R6: If any phase inside a measurement lasts MIN_PH ticks or fewer (default 2), `res_runt` is 1 and `res_data` is 0. A phase of MIN_PH+1 ticks is reported normally. The runt flag takes precedence over overflow.
- R7: An interval of 2^LOOP_W loop periods or more sets `res_ovf` and saturates `res_data` to all ones. An interval of exactly 2^W−1 ticks is reported without the flag.
- R8: `res_valid` is high for exactly one cycle per completed measurement. `res_data` and the flags change only in that cycle.
- R9: A result arriving while `res_pending` is 1 (not yet acknowledged by `rd_ack`) sets `res_overrun`. `res_overrun` stays set until the next `cfg_load`. `rd_ack` clears `res_pending`.
- R10: `cfg_load` abandons any measurement in progress and clears pending and overrun. Capture then waits for a new start edge, so an end edge seen before that start edge produces no result.
- R11: After reset all outputs are 0, and the mode is code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Asynchronous signal to measure |
| cfg_load | input | 1 | Load strobe: takes `cfg_mode` and re-arms capture |
| cfg_mode | input | 2 | Mode code (0 rise period, 1 fall period, 2 high, 3 low) |
| rd_ack | input | 1 | Acknowledges the current result |
| res_data | output | LOOP_W+log2(LR_DIV) | {loop count, sub-loop tick count} |
| res_valid | output | 1 | One-cycle strobe on each new result |
| res_ovf | output | 1 | Result exceeded the counter range |
| res_runt | output | 1 | A phase was at or below the minimum width |
| res_overrun | output | 1 | Sticky: a pending result was overwritten |
| res_pending | output | 1 | A result awaits acknowledgement |

## Verification
The bench builds the block with HR_DIV = 1, LR_DIV = 4 and LOOP_W = 6. Every clock is therefore a tick, and an input phase driven for N clocks measures exactly N. The narrow 8-bit result puts the overflow boundary at 255 ticks, so both 255 and 256 can be reached in a few hundred cycles. The four-tick loop makes the split between loop count and sub-loop count visible in small values. Runt phases of one and two ticks, and the first measurable width of three ticks, are driven directly.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    typedef enum logic [1:0] {
        MODE_PER_RISE = 2'd0,
        MODE_PER_FALL = 2'd1,
        MODE_HIGH     = 2'd2,
        MODE_LOW      = 2'd3
    } hpc_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } hpc_edge_t;

    typedef struct packed {
        logic ovf;
        logic runt;
    } hpc_flags_t;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_RUN   = 1'b1
    } hpc_state_e;

    function automatic logic start_hit(hpc_mode_e m, hpc_edge_t e);
        case (m)
            MODE_PER_RISE: return e.rise;
            MODE_PER_FALL: return e.fall;
            MODE_HIGH:     return e.rise;
            default:       return e.fall;
        endcase
    endfunction

    function automatic logic end_hit(hpc_mode_e m, hpc_edge_t e);
        case (m)
            MODE_PER_RISE: return e.rise;
            MODE_PER_FALL: return e.fall;
            MODE_HIGH:     return e.fall;
            default:       return e.rise;
        endcase
    endfunction

    function automatic logic is_period(hpc_mode_e m);
        return (m == MODE_PER_RISE) || (m == MODE_PER_FALL);
    endfunction

endpackage

// File: rtl/hpc_tick_gen.sv
module hpc_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/hpc_edge_sync.sv
module hpc_edge_sync
    import hpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      din,
    output hpc_edge_t edges
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            if (tick) begin
                prev_q <= sync_q;
            end
        end
    end

    always_comb begin
        edges.rise = tick &  sync_q & ~prev_q;
        edges.fall = tick & ~sync_q &  prev_q;
    end
endmodule

// File: rtl/hpc_interval.sv
module hpc_interval
    import hpc_pkg::*;
#(
    parameter int W      = 30,
    parameter int MIN_PH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rearm,
    input  logic         tick,
    input  hpc_edge_t    edges,
    input  hpc_mode_e    mode,
    output logic         done,
    output logic [W-1:0] value,
    output hpc_flags_t   flags
);
    localparam int PW = $clog2(MIN_PH + 1) + 1;

    hpc_state_e    state;
    logic [W-1:0]  cnt;
    logic          ovf_run;
    logic          runt_run;
    logic [PW-1:0] pcnt;

    logic          s_hit;
    logic          e_hit;
    logic          any_edge;
    logic [W:0]    cnt_inc;
    logic          ovf_now;
    logic          runt_now;
    logic          runt_fin;

    always_comb begin
        s_hit    = start_hit(mode, edges);
        e_hit    = end_hit(mode, edges);
        any_edge = edges.rise | edges.fall;
        cnt_inc  = {1'b0, cnt} + 1'b1;
        ovf_now  = ovf_run | cnt_inc[W];
        runt_now = any_edge && (pcnt < PW'(MIN_PH));
        runt_fin = runt_run | runt_now;
    end

    // phase length tracker, saturating just above the minimum
    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (tick) begin
            if (any_edge) begin
                pcnt <= '0;
            end else if (pcnt != PW'(MIN_PH)) begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            flags <= '0;
        end else if (tick && state == ST_RUN && e_hit && !rearm) begin
            flags.ovf  <= ovf_now;
            flags.runt <= runt_fin;
            if (runt_fin) begin
                value <= '0;
            end else if (ovf_now) begin
                value <= '1;
            end else begin
                value <= cnt_inc[W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            state    <= ST_ARMED;
            cnt      <= '0;
            ovf_run  <= 1'b0;
            runt_run <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_ARMED: begin
                        if (s_hit) begin
                            state    <= ST_RUN;
                            cnt      <= '0;
                            ovf_run  <= 1'b0;
                            runt_run <= 1'b0;
                        end
                    end
                    default: begin
                        if (e_hit) begin
                            done     <= 1'b1;
                            cnt      <= '0;
                            ovf_run  <= 1'b0;
                            runt_run <= 1'b0;
                            if (!is_period(mode)) begin
                                state <= ST_ARMED;
                            end
                        end else begin
                            if (cnt_inc[W]) begin
                                ovf_run <= 1'b1;
                            end else begin
                                cnt <= cnt_inc[W-1:0];
                            end
                            if (runt_now) begin
                                runt_run <= 1'b1;
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/hpc_result.sv
module hpc_result
    import hpc_pkg::*;
#(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         done,
    input  logic [W-1:0] value,
    input  hpc_flags_t   flags,
    input  logic         rd_ack,
    output logic [W-1:0] res_data,
    output logic         res_valid,
    output logic         res_ovf,
    output logic         res_runt,
    output logic         res_overrun,
    output logic         res_pending
);
    logic take;

    assign take = done & ~clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data    <= '0;
            res_valid   <= 1'b0;
            res_ovf     <= 1'b0;
            res_runt    <= 1'b0;
            res_overrun <= 1'b0;
            res_pending <= 1'b0;
        end else begin
            res_valid <= take;
            if (take) begin
                res_data <= value;
                res_ovf  <= flags.ovf;
                res_runt <= flags.runt;
            end
            if (clr) begin
                res_pending <= 1'b0;
                res_overrun <= 1'b0;
            end else begin
                if (take) begin
                    res_pending <= 1'b1;
                end else if (rd_ack) begin
                    res_pending <= 1'b0;
                end
                if (take && res_pending && !rd_ack) begin
                    res_overrun <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hpc_capture.sv
module hpc_capture
    import hpc_pkg::*;
#(
    parameter int HR_DIV = 8,
    parameter int LR_DIV = 32,
    parameter int LOOP_W = 25,
    parameter int MIN_PH = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                din,
    input  logic                                cfg_load,
    input  logic [1:0]                          cfg_mode,
    input  logic                                rd_ack,
    output logic [LOOP_W+$clog2(LR_DIV)-1:0]    res_data,
    output logic                                res_valid,
    output logic                                res_ovf,
    output logic                                res_runt,
    output logic                                res_overrun,
    output logic                                res_pending
);
    localparam int SUB_W = $clog2(LR_DIV);
    localparam int W     = LOOP_W + SUB_W;

    logic         tick;
    hpc_edge_t    edges;
    hpc_mode_e    mode_q;
    logic         done;
    logic [W-1:0] value;
    hpc_flags_t   flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_PER_RISE;
        end else if (cfg_load) begin
            mode_q <= hpc_mode_e'(cfg_mode);
        end
    end

    hpc_tick_gen #(.DIV(HR_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    hpc_edge_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .din   (din),
        .edges (edges)
    );

    hpc_interval #(.W(W), .MIN_PH(MIN_PH)) u_ivl (
        .clk   (clk),
        .rst   (rst),
        .rearm (cfg_load),
        .tick  (tick),
        .edges (edges),
        .mode  (mode_q),
        .done  (done),
        .value (value),
        .flags (flags)
    );

    hpc_result #(.W(W)) u_res (
        .clk         (clk),
        .rst         (rst),
        .clr         (cfg_load),
        .done        (done),
        .value       (value),
        .flags       (flags),
        .rd_ack      (rd_ack),
        .res_data    (res_data),
        .res_valid   (res_valid),
        .res_ovf     (res_ovf),
        .res_runt    (res_runt),
        .res_overrun (res_overrun),
        .res_pending (res_pending)
    );
endmodule

// File: rtl/hpc_capture_chk.sv
module hpc_capture_chk #(
    parameter int W = 30
) (
    input logic         clk,
    input logic         rst,
    input logic         cfg_load,
    input logic [W-1:0] res_data,
    input logic         res_valid,
    input logic         res_ovf,
    input logic         res_runt,
    input logic         res_overrun,
    input logic         res_pending
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R8

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_data)); // R8

    AST_RUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_runt) |-> (res_data == '0)); // R6

    AST_OVF_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ovf && !res_runt) |-> (&res_data)); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (res_overrun && !cfg_load) |=> res_overrun); // R9

    AST_PENDING_ON_VALID: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_pending); // R9

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (!res_overrun && !res_pending)); // R10
endmodule

bind hpc_capture hpc_capture_chk #(.W(LOOP_W + $clog2(LR_DIV))) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_load    (cfg_load),
    .res_data    (res_data),
    .res_valid   (res_valid),
    .res_ovf     (res_ovf),
    .res_runt    (res_runt),
    .res_overrun (res_overrun),
    .res_pending (res_pending)
);

// File: tb/hpc_capture_tb.sv
module hpc_capture_tb;
    localparam int HRD = 1;
    localparam int LRD = 4;
    localparam int LW  = 6;
    localparam int W   = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         din = 1'b0;
    logic         cfg_load = 1'b0;
    logic [1:0]   cfg_mode = 2'd0;
    logic         auto_pulse = 1'b0;
    logic         man_ack = 1'b0;
    logic         rd_ack;
    logic [W-1:0] res_data;
    logic         res_valid, res_ovf, res_runt, res_overrun, res_pending;

    assign rd_ack = auto_pulse | man_ack;

    always #5 clk = ~clk;

    hpc_capture #(.HR_DIV(HRD), .LR_DIV(LRD), .LOOP_W(LW), .MIN_PH(2)) u_dut (
        .clk(clk), .rst(rst), .din(din), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .rd_ack(rd_ack), .res_data(res_data), .res_valid(res_valid), .res_ovf(res_ovf),
        .res_runt(res_runt), .res_overrun(res_overrun), .res_pending(res_pending)
    );

    typedef struct {
        int    data;
        bit    ovf;
        bit    runt;
        string req;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   n_seen = 0;
    int   n_pushed = 0;
    bit   auto_ack = 1'b1;
    bit   finished = 1'b0;
    bit   prev_valid = 1'b0;
    logic [W-1:0] last_data = '0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_res(int data, bit ovf, bit runt, string req);
        exp_t e;
        e.data = data; e.ovf = ovf; e.runt = runt; e.req = req;
        sb.push_back(e);
        n_pushed++;
    endtask

    task automatic drive(logic lvl, int n);
        din = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(logic [1:0] m);
        cfg_mode = m;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // monitor: pops expected results as the design produces them
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            n_seen++;
            if (prev_valid) begin
                check(1'b0, "R8", "valid held two cycles", 2, 1);
            end
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected result data", int'(res_data), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check((int'(res_data) == e.data) && (res_ovf == e.ovf) && (res_runt == e.runt),
                      e.req, $sformatf("data/ovf/runt (ovf=%0b runt=%0b, exp ovf=%0b runt=%0b)",
                      res_ovf, res_runt, e.ovf, e.runt), int'(res_data), e.data);
            end
            last_data = res_data;
            auto_pulse = auto_ack;
        end else begin
            auto_pulse = 1'b0;
        end
        prev_valid = res_valid;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog expired: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check({res_data, res_valid, res_ovf, res_runt, res_overrun, res_pending} == '0,
              "R11", "outputs after reset", int'(res_data), 0);

        // R1 / R5 / R6: rising-to-rising period (mode left at reset default)
        expect_res(16, 0, 0, "R1");
        expect_res(10, 0, 0, "R1");
        expect_res(13, 0, 0, "R5");
        expect_res(0,  0, 1, "R6");
        drive(0, 4);
        drive(1, 7); drive(0, 9);
        drive(1, 4); drive(0, 6);
        drive(1, 6); drive(0, 7);
        drive(1, 5);
        // R5: 13 ticks with LR_DIV=4 reads as loop 3, sub 1
        check(last_data[W-1:2] == 6'd3 && last_data[1:0] == 2'd1, "R5",
              "loop/sub split of 13", int'(last_data), 13);
        drive(0, 2);
        drive(1, 6); drive(0, 8);

        // R2: falling-to-falling period
        do_load(2'd1);
        expect_res(9,  0, 0, "R2");
        expect_res(12, 0, 0, "R2");
        drive(1, 5); drive(0, 6);
        drive(1, 3); drive(0, 4);
        drive(1, 8); drive(0, 8);

        // R3 / R6 / R7: high phase, runts, overflow boundary
        do_load(2'd2);
        expect_res(11,  0, 0, "R3");
        expect_res(3,   0, 0, "R6");
        expect_res(0,   0, 1, "R6");
        expect_res(0,   0, 1, "R6");
        expect_res(255, 0, 0, "R7");
        expect_res(255, 1, 0, "R7");
        expect_res(255, 1, 0, "R7");
        drive(1, 11);  drive(0, 4);
        drive(1, 3);   drive(0, 4);
        drive(1, 2);   drive(0, 4);
        drive(1, 1);   drive(0, 4);
        drive(1, 255); drive(0, 4);
        drive(1, 256); drive(0, 4);
        drive(1, 300); drive(0, 6);

        // R4 / R6: low phase
        do_load(2'd3);
        expect_res(9, 0, 0, "R4");
        expect_res(5, 0, 0, "R4");
        expect_res(0, 0, 1, "R6");
        drive(1, 5); drive(0, 9);
        drive(1, 3); drive(0, 5);
        drive(1, 4); drive(0, 2);
        drive(1, 8);

        // R10: load abandons a running measurement; a lone end edge is ignored
        do_load(2'd2);
        drive(1, 4); drive(0, 5);
        drive(1, 5);
        do_load(2'd2);
        drive(1, 3); drive(0, 5);
        check(sb.size() == 0 && res_pending == 1'b0, "R10", "results after abandoned capture",
              sb.size(), 0);
        expect_res(6, 0, 0, "R10");
        drive(1, 6); drive(0, 8);

        // R9: overrun, acknowledge, clear on load
        auto_ack = 1'b0;
        do_load(2'd2);
        expect_res(4, 0, 0, "R9");
        expect_res(5, 0, 0, "R9");
        drive(1, 4); drive(0, 4);
        check(res_pending == 1'b1 && res_overrun == 1'b0, "R9", "pending after first result",
              int'({res_pending, res_overrun}), 2);
        drive(1, 5); drive(0, 6);
        check(res_overrun == 1'b1, "R9", "overrun after unread result", res_overrun, 1);
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        check(res_pending == 1'b0, "R9", "pending after ack", res_pending, 0);
        check(res_overrun == 1'b1, "R9", "overrun sticky after ack", res_overrun, 1);
        do_load(2'd2);
        check(res_overrun == 1'b0, "R9", "overrun after load", res_overrun, 0);
        auto_ack = 1'b1;

        repeat (10) @(negedge clk);
        check(sb.size() == 0, "R10", "expected results left unconsumed", sb.size(), 0);
        check(n_seen == n_pushed, "R8", "result strobe count", n_seen, n_pushed);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule